// File: doc/BRIEF.md
# Hot-Plug Slot Command Processor

This block executes the command codes that software writes to a hot-plug controller. Each write presents an eight-bit code and a target byte on a single-cycle strobe. Codes below 0x40 act on one slot. Within such a code, bits 1:0 request a slot state, bits 3:2 set the power indicator and bits 5:4 set the attention indicator. Codes 0x40 to 0x47 select the secondary bus speed. Code 0x48 puts every slot into power-only, and code 0x49 enables every slot.

The block holds one twelve-bit status word and one five-bit event latch per slot, and shows them on flat read ports. Three command status flags report the outcome: busy, invalid command and invalid mode. A sticky command-detected flag feeds the interrupt logic and is set when each command finishes. Single-slot, speed and illegal commands complete on the clock edge that samples the strobe. The two all-slot commands walk the slots one per cycle and finish with a one-cycle done pulse.

Top module: `hp_cmd_proc`

## Requirements
- R1: During reset, each occupied slot takes status 0x006: enabled (state 2), power indicator on (1), MRL closed, presence 0. Each unoccupied slot takes status 0xD0F: disabled (3), power indicator off (3), MRL open (bit 8), presence empty (bits 11:10 = 3). All event latches and flags are zero.
- R2: In a slot command, a nonzero indicator field replaces its status field: power indicator in bits 3:2, attention indicator in bits 5:4. The encoding is 1 on, 2 blink, 3 off. Disabled to power-only (1), disabled to enabled (2), enabled to disabled and power-only to disabled are the accepted state changes.
- R3: Only the low five bits of the target are used. A target of 0, or a target greater than NSLOTS, sets the invalid-command flag and changes no slot.
- R4: Requesting power-only for an enabled slot sets the invalid-command flag and leaves that slot's status, indicators included, unchanged.
- R5: Any other state request leaves the slot state unchanged. This covers state 0, power-only to enabled, and disabled to disabled. Indicator fields are still applied.
- R6: A change to disabled with the power indicator then off marks the slot empty. MRL-open is set, presence goes to 3, and event latch bits 0 (presence), 2 (button) and 3 (MRL) are set.
- R7: Codes 0x40 to 0x47 with low three bits zero are accepted. Any other low value sets the invalid-mode flag.
- R8: Codes 0x48 and 0x49 set the invalid-command flag and change nothing if any slot is enabled.
- R9: Otherwise an all-slot command raises busy, then handles one slot per cycle in index order. A slot with MRL closed gets power-only (0x48) or enabled (0x49) with its power indicator on. A slot with MRL open gets no state request and its power indicator off. After the last slot, busy drops and done pulses for one cycle.
- R10: Every other code sets invalid-command. Every accepted command first clears the invalid-command and invalid-mode flags.
- R11: The command-detected flag is set when every command completes, failed ones included. The det_clr input clears it, and a completion in the same cycle wins.
- R12: A command strobe that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_occupied | input | NSLOTS | Per-slot occupancy, sampled during reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| cmd_target | input | 8 | Target slot number, low five bits used |
| det_clr | input | 1 | Clears command-detected |
| slot_status | output | NSLOTS*12 | Status words, slot 0 in the low bits |
| slot_events | output | NSLOTS*5 | Event latches, slot 0 in the low bits |
| busy | output | 1 | All-slot command in progress |
| inv_cmd | output | 1 | Invalid-command flag |
| inv_mode | output | 1 | Invalid-mode flag |
| cmd_detected | output | 1 | Sticky command-completion flag |
| all_done | output | 1 | One-cycle pulse after an all-slot command |

## Verification
The bench builds the block with NSLOTS = 4, with slots 0 and 1 occupied. This makes targets 5 and above out of range. It also keeps the all-slot walk to four cycles, so busy and the done pulse can be watched directly. The mixed occupancy puts an enabled slot in place to refuse the first all-slot command. Later commands move slots through every accepted and rejected transition, so the all-slot commands then meet one slot with MRL closed and three with MRL open.

// File: rtl/hp_cmd_proc.sv
module hp_cmd_proc #(
  parameter int NSLOTS = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSLOTS-1:0]    slot_occupied,
  input  logic                 cmd_wr,
  input  logic [7:0]           cmd_code,
  input  logic [7:0]           cmd_target,
  input  logic                 det_clr,
  output logic [NSLOTS*12-1:0] slot_status,
  output logic [NSLOTS*5-1:0]  slot_events,
  output logic                 busy,
  output logic                 inv_cmd,
  output logic                 inv_mode,
  output logic                 cmd_detected,
  output logic                 all_done
);
  localparam int SW = 12;
  localparam int EW = 5;
  localparam int IW = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;
  localparam logic [SW-1:0] ST_FULL  = 12'h006;
  localparam logic [SW-1:0] ST_EMPTY = 12'hD0F;

  logic [SW-1:0] st_q [NSLOTS];
  logic [EW-1:0] ev_q [NSLOTS];
  logic [IW-1:0] idx_q;
  logic          en_all_q;

  function automatic logic [EW+SW-1:0] apply(input logic [EW+SW-1:0] cur,
                                             input logic [1:0] rs,
                                             input logic [1:0] pw,
                                             input logic [1:0] at);
    logic [SW-1:0] s;
    logic [EW-1:0] e;
    s = cur[SW-1:0];
    e = cur[EW+SW-1:SW];
    if (pw != 2'd0) s[3:2] = pw;
    if (at != 2'd0) s[5:4] = at;
    if (cur[1:0] == 2'd3 && (rs == 2'd1 || rs == 2'd2)) begin
      s[1:0] = rs;
    end else if ((cur[1:0] == 2'd1 || cur[1:0] == 2'd2) && rs == 2'd3) begin
      s[1:0] = 2'd3;
      if (s[3:2] == 2'd3) begin
        s[8]     = 1'b1;
        s[11:10] = 2'd3;
        e        = e | 5'b01101;
      end
    end
    return {e, s};
  endfunction

  logic [4:0]          tgt;
  logic                tgt_bad;
  logic [IW-1:0]       sel;
  logic [EW+SW-1:0]    nxt_sel, nxt_it;
  logic                any_en;
  logic                it_mrl;

  assign tgt     = cmd_target[4:0];
  assign tgt_bad = (tgt == 5'd0) || (int'(tgt) > NSLOTS);
  assign sel     = IW'(tgt - 5'd1);
  assign nxt_sel = apply({ev_q[sel], st_q[sel]}, cmd_code[1:0], cmd_code[3:2], cmd_code[5:4]);
  assign it_mrl  = st_q[idx_q][8];
  assign nxt_it  = apply({ev_q[idx_q], st_q[idx_q]},
                         it_mrl ? 2'd0 : (en_all_q ? 2'd2 : 2'd1),
                         it_mrl ? 2'd3 : 2'd1, 2'd0);

  always_comb begin
    any_en = 1'b0;
    for (int i = 0; i < NSLOTS; i++)
      if (st_q[i][1:0] == 2'd2) any_en = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOTS; i++) begin
        st_q[i] <= slot_occupied[i] ? ST_FULL : ST_EMPTY;
        ev_q[i] <= '0;
      end
      idx_q        <= '0;
      en_all_q     <= 1'b0;
      busy         <= 1'b0;
      inv_cmd      <= 1'b0;
      inv_mode     <= 1'b0;
      cmd_detected <= 1'b0;
      all_done     <= 1'b0;
    end else begin
      all_done <= 1'b0;
      if (det_clr) cmd_detected <= 1'b0;
      if (busy) begin
        st_q[idx_q] <= nxt_it[SW-1:0];
        ev_q[idx_q] <= nxt_it[EW+SW-1:SW];
        if (int'(idx_q) == NSLOTS - 1) begin
          busy         <= 1'b0;
          all_done     <= 1'b1;
          cmd_detected <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else if (cmd_wr) begin
        inv_cmd      <= 1'b0;
        inv_mode     <= 1'b0;
        cmd_detected <= 1'b1;
        if (cmd_code < 8'h40) begin
          if (tgt_bad) begin
            inv_cmd <= 1'b1;
          end else if (st_q[sel][1:0] == 2'd2 && cmd_code[1:0] == 2'd1) begin
            inv_cmd <= 1'b1;
          end else begin
            st_q[sel] <= nxt_sel[SW-1:0];
            ev_q[sel] <= nxt_sel[EW+SW-1:SW];
          end
        end else if (cmd_code < 8'h48) begin
          if (cmd_code[2:0] != 3'd0) inv_mode <= 1'b1;
        end else if (cmd_code == 8'h48 || cmd_code == 8'h49) begin
          if (any_en) begin
            inv_cmd <= 1'b1;
          end else begin
            busy         <= 1'b1;
            idx_q        <= '0;
            en_all_q     <= cmd_code[0];
            cmd_detected <= cmd_detected & ~det_clr;
          end
        end else begin
          inv_cmd <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NSLOTS; g++) begin : g_out
    assign slot_status[g*SW +: SW] = st_q[g];
    assign slot_events[g*EW +: EW] = ev_q[g];

    a_r5_no_pwronly_to_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g][1:0] == 2'd1) |=> (st_q[g][1:0] != 2'd2));

    a_r6_empty_only_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q[g][8]) |-> (st_q[g][1:0] == 2'd3 && st_q[g][3:2] == 2'd3 && ev_q[g][3]));
  end

  a_r9_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |=> !all_done);

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |-> !busy);

  a_r11_done_sets_detected: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |-> cmd_detected);

  a_r12_flags_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(inv_cmd) && $stable(inv_mode)));
endmodule

// File: tb/sim_hp_cmd_proc.sv
module sim_hp_cmd_proc;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] occ = 4'b0011;
  logic cmd_wr = 1'b0;
  logic [7:0] code = '0, tgt = '0;
  logic det_clr = 1'b0;
  logic [N*12-1:0] st;
  logic [N*5-1:0] ev;
  logic busy, inv_cmd, inv_mode, det, done;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  hp_cmd_proc #(.NSLOTS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_occupied(occ), .cmd_wr(cmd_wr),
    .cmd_code(code), .cmd_target(tgt), .det_clr(det_clr),
    .slot_status(st), .slot_events(ev), .busy(busy), .inv_cmd(inv_cmd),
    .inv_mode(inv_mode), .cmd_detected(det), .all_done(done));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] s(input int i);
    return st[i*12 +: 12];
  endfunction
  function automatic logic [4:0] e(input int i);
    return ev[i*5 +: 5];
  endfunction

  task automatic issue(input logic [7:0] c, input logic [7:0] t);
    code = c; tgt = t; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int seen = 0;
    for (int k = 0; k < 50 && seen == 0; k++) begin
      if (done) seen = 1; else @(negedge clk);
    end
    chk(req, seen, 1);
  endtask

  task automatic t_reset;
    chk("R1 s0", s(0), 12'h006); chk("R1 s1", s(1), 12'h006);
    chk("R1 s2", s(2), 12'hD0F); chk("R1 s3", s(3), 12'hD0F);
    chk("R1 ev", ev, '0);
    chk("R1 flags", {busy, inv_cmd, inv_mode, det, done}, 0);
  endtask

  task automatic t_all_refused;
    issue(8'h49, 8'd0);
    chk("R8 inv", inv_cmd, 1); chk("R8 busy", busy, 0);
    chk("R8 s0", s(0), 12'h006); chk("R11 det", det, 1);
    det_clr = 1'b1; @(negedge clk); det_clr = 1'b0;
    chk("R11 clr", det, 0);
  endtask

  task automatic t_bad_target;
    issue(8'h05, 8'd0);
    chk("R3 t0", inv_cmd, 1); chk("R3 t0 s0", s(0), 12'h006);
    issue(8'h05, 8'd5);
    chk("R3 t5", inv_cmd, 1);
    chk("R3 unchanged", st, {12'hD0F, 12'hD0F, 12'h006, 12'h006});
    issue(8'h2C, 8'h24);
    chk("R3 mask inv", inv_cmd, 0); chk("R3 mask s3", s(3), 12'hD2F);
  endtask

  task automatic t_pwronly_enabled;
    issue(8'h15, 8'd1);
    chk("R4 inv", inv_cmd, 1); chk("R4 s0", s(0), 12'h006);
  endtask

  task automatic t_slot_edits;
    issue(8'h0B, 8'd1);
    chk("R2 disable blink", s(0), 12'h00B); chk("R2 ev0", e(0), 0);
    chk("R10 cleared", inv_cmd, 0);
    issue(8'h2C, 8'd1);
    chk("R2 led only", s(0), 12'h02F);
    issue(8'h03, 8'd1);
    chk("R5 dis to dis", s(0), 12'h02F); chk("R5 ev0", e(0), 0);
  endtask

  task automatic t_empty;
    issue(8'h0F, 8'd2);
    chk("R6 s1", s(1), 12'hD0F); chk("R6 ev1", e(1), 5'h0D);
  endtask

  task automatic t_speed;
    issue(8'h40, 8'd0);
    chk("R7 ok", {inv_mode, inv_cmd}, 0);
    issue(8'h43, 8'd0);
    chk("R7 bad", {inv_mode, inv_cmd}, 2'b10);
    issue(8'h40, 8'd0);
    chk("R10 mode cleared", inv_mode, 0);
  endtask

  task automatic t_bad_code;
    issue(8'h50, 8'd1);
    chk("R10 0x50", {inv_cmd, inv_mode}, 2'b10);
    issue(8'hFF, 8'd1);
    chk("R10 0xFF", inv_cmd, 1);
  endtask

  task automatic t_all_pwr;
    det_clr = 1'b1; @(negedge clk); det_clr = 1'b0;
    issue(8'h48, 8'd0);
    chk("R9 busy", busy, 1); chk("R9 inv cleared", inv_cmd, 0);
    chk("R11 det not yet", det, 0);
    issue(8'h50, 8'd1);
    wait_done("R9 done");
    chk("R12 ignored", inv_cmd, 0); chk("R11 det", det, 1);
    chk("R9 status", st, {12'hD2F, 12'hD0F, 12'hD0F, 12'h025});
    @(negedge clk);
    chk("R9 pulse", {done, busy}, 0);
  endtask

  task automatic t_all_en;
    issue(8'h49, 8'd0);
    wait_done("R9 done en");
    chk("R5 pwr to en", s(0), 12'h025);
    chk("R9 en others", st[47:12], {12'hD2F, 12'hD0F, 12'hD0F});
    issue(8'h03, 8'd1);
    chk("R2 pwr to dis", s(0), 12'h027); chk("R6 not empty", e(0), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_refused();
    t_bad_target();
    t_pwronly_enabled();
    t_slot_edits();
    t_empty();
    t_speed();
    t_bad_code();
    t_all_pwr();
    t_all_en();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule